// File: doc/BRIEF.md
# DDR Self-Refresh Entry/Exit Sequencer

This block sits inside a DDR SDRAM memory controller and takes the device into and out of its self-refresh low-power state. When the rest of the controller asks for low power, the sequencer takes the command bus. If any bank is still open, it closes all banks first and waits out the precharge time. It then issues the auto-refresh command in the same cycle that it pulls clock enable low. The device stays in self-refresh until an exit is requested and the controller reports that the memory clock is stable.

On exit, clock enable is raised with only NOP on the bus. Two separate wake-up delays then run from the same point. A shorter one, derived from a nanosecond figure, guards all non-READ commands. A longer one, counted in clock cycles, guards READ commands. The scheduler sees `nonread_ok` rise first and `read_ok` later. `busy` tells it to stay off the bus from the accepted entry request until READs are allowed again.

The nanosecond figures are turned into cycle counts by rounding up against the clock-period parameter. Every output is registered, so clock enable and the command launch straight from flops and meet the device's setup and hold window.

Top module: `lp_selfref_seq`

## Requirements
- R1: After reset the block drives `cke`=1, `cmd`=NOP, `busy`=0, `nonread_ok`=1 and `read_ok`=1.
- R2: Command encoding on `cmd` is {RAS_n, CAS_n, WE_n}: NOP=3'b111, PRECHARGE ALL=3'b010, AUTO REFRESH=3'b001. When `enter_req` is accepted with `banks_open`=1, PRECHARGE ALL appears in the cycle after the accepting edge. AUTO REFRESH follows exactly RP cycles later, where RP = ceil(TRP_PS / CLK_PS).
- R3: When `enter_req` is accepted with `banks_open`=0, AUTO REFRESH appears in the cycle after the accepting edge with no PRECHARGE ALL. In every case `cke` is driven low in the same cycle as AUTO REFRESH.
- R4: While `cke` is low, the only command other than NOP is the single AUTO REFRESH that lowered it. AUTO REFRESH is issued once per entry.
- R5: `cke` rises only after `clk_stable` has been sampled high together with a pending exit request. It never rises earlier than the second cycle of the self-refresh state.
- R6: An `exit_req` pulse that arrives with the accepted `enter_req` or at any point during entry is held and serviced once the device is in self-refresh. Entry always completes.
- R7: `nonread_ok` falls when the entry request is accepted. It rises exactly NR cycles after `cke` rises, where NR = ceil(TXSNR_PS / CLK_PS).
- R8: `read_ok` rises exactly TXSRD_CYC cycles after `cke` rises, and `busy` falls in that same cycle. TXSRD_CYC must exceed NR.
- R9: `busy` rises in the cycle after the accepting edge and stays high until `read_ok` rises. `read_ok` is never high while `busy` is high.
- R10: `enter_req` has no effect while `busy` is high. `exit_req` has no effect when no entry is in progress: it is neither acted on nor remembered for a later entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enter_req | input | 1 | Request to enter self-refresh (sampled while idle) |
| exit_req | input | 1 | Request to leave self-refresh (pulse or level) |
| clk_stable | input | 1 | Memory clock running within specification |
| banks_open | input | 1 | At least one bank is open |
| cke | output | 1 | Registered clock enable to the device |
| cmd | output | 3 | Registered command {RAS_n, CAS_n, WE_n} |
| busy | output | 1 | Sequencer owns the command bus |
| nonread_ok | output | 1 | Non-READ commands may be issued |
| read_ok | output | 1 | READ commands may be issued |

## Verification
The bench builds the block with CLK_PS=7500, TRP_PS=20000, TXSNR_PS=30000 and TXSRD_CYC=24. That gives a 3-cycle precharge wait, a 4-cycle non-READ delay and a 24-cycle READ delay. Because the READ delay is short, dozens of complete entry/exit episodes fit in one run. An exit request can then be placed at the accepting edge, inside the precharge wait, on the auto-refresh cycle, and well after entry. The clock-stable signal is raised either before or long after the exit request. Each episode's edge-exact event times are compared with times the bench derives from these parameters.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRECHARGE,
    ST_WAIT_RP,
    ST_ENTER,
    ST_IN_SR,
    ST_EXIT_WAIT,
    ST_READY
  } lp_state_e;

  // {RAS_n, CAS_n, WE_n}
  typedef logic [2:0] ddr_cmd_t;

  localparam ddr_cmd_t CMD_NOP    = 3'b111;
  localparam ddr_cmd_t CMD_PREALL = 3'b010;
  localparam ddr_cmd_t CMD_AREF   = 3'b001;

  typedef struct packed {
    logic     cke;
    ddr_cmd_t cmd;
    logic     busy;
    logic     nonread_ok;
    logic     read_ok;
  } seq_out_t;

  // Round a picosecond figure up to whole clock cycles.
  function automatic int ps_to_cycles(input int span_ps, input int clk_ps);
    return (span_ps + clk_ps - 1) / clk_ps;
  endfunction

endpackage

// File: rtl/lp_rst_sync.sv
module lp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/lp_seq_timer.sv
module lp_seq_timer #(
  parameter int RP_CYC = 3,
  parameter int NR_CYC = 10,
  parameter int RD_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic rp_hit,
  output logic nr_hit,
  output logic rd_hit
);

  localparam int CMAX = (RD_CYC > RP_CYC) ? RD_CYC : RP_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(CMAX);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // Counts cycles while run is high; clears whenever run drops.
  always_comb begin
    if (!run)                cnt_d = '0;
    else if (cnt_q != CNT_TOP) cnt_d = cnt_q + 1'b1;
    else                     cnt_d = cnt_q;
  end

  assign cnt_en = run || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign rp_hit = run && (cnt_q == CW'(RP_CYC - 1));
  assign nr_hit = run && (cnt_q == CW'(NR_CYC - 1));
  assign rd_hit = run && (cnt_q == CW'(RD_CYC - 1));

  // R8: the non-READ delay is always shorter than the READ delay
  a_r8_nr_before_rd: assert property (@(posedge clk) disable iff (!rst_n)
    nr_hit |-> !rd_hit);

  // R2: a fresh count starts from zero the cycle after run rises
  a_r2_count_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt_q == '0));

endmodule

// File: rtl/lp_seq_fsm.sv
module lp_seq_fsm
  import lp_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     enter_req,
  input  logic     exit_req,
  input  logic     clk_stable,
  input  logic     banks_open,
  input  logic     rp_hit,
  input  logic     nr_hit,
  input  logic     rd_hit,
  output logic     timer_run,
  output seq_out_t out_q
);

  function automatic seq_out_t decode(input lp_state_e s);
    seq_out_t o;
    o.cke        = 1'b1;
    o.cmd        = CMD_NOP;
    o.busy       = 1'b1;
    o.nonread_ok = 1'b0;
    o.read_ok    = 1'b0;
    case (s)
      ST_IDLE: begin
        o.busy       = 1'b0;
        o.nonread_ok = 1'b1;
        o.read_ok    = 1'b1;
      end
      ST_PRECHARGE: o.cmd = CMD_PREALL;
      ST_ENTER: begin
        o.cke = 1'b0;
        o.cmd = CMD_AREF;
      end
      ST_IN_SR:  o.cke        = 1'b0;
      ST_READY:  o.nonread_ok = 1'b1;
      default: ;
    endcase
    return o;
  endfunction

  lp_state_e state_q, state_d;
  logic      exit_pend_q;
  logic      exit_go, entry_phase, pend_set, pend_clr, pend_en;

  assign exit_go     = (exit_pend_q || exit_req) && clk_stable;
  assign entry_phase = (state_q inside {ST_PRECHARGE, ST_WAIT_RP, ST_ENTER, ST_IN_SR}) ||
                       ((state_q == ST_IDLE) && enter_req);
  assign pend_set    = exit_req && entry_phase;
  assign pend_clr    = (state_q == ST_IN_SR) && exit_go;
  assign pend_en     = pend_set || pend_clr;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:                  if (enter_req) state_d = banks_open ? ST_PRECHARGE : ST_ENTER;
      ST_PRECHARGE, ST_WAIT_RP: state_d = rp_hit ? ST_ENTER : ST_WAIT_RP;
      ST_ENTER:                 state_d = ST_IN_SR;
      ST_IN_SR:                 if (exit_go) state_d = ST_EXIT_WAIT;
      ST_EXIT_WAIT:             if (nr_hit) state_d = ST_READY;
      ST_READY:                 if (rd_hit) state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  assign timer_run = state_q inside {ST_PRECHARGE, ST_WAIT_RP, ST_EXIT_WAIT, ST_READY};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       exit_pend_q <= 1'b0;
    else if (pend_en) exit_pend_q <= !pend_clr;
  end

  // Outputs launched from flops, decoded from the next state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= decode(ST_IDLE);
    else        out_q <= decode(state_d);
  end

  // R3: auto refresh only on the cycle clock enable falls
  a_r3_aref_drops_cke: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q.cmd == CMD_AREF) |-> (!out_q.cke && $past(out_q.cke)));

  // R4: after clock enable falls the bus idles
  a_r4_nop_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_q.cke) |=> (out_q.cmd == CMD_NOP));

  // R5: clock enable rises only with a stable clock
  a_r5_rise_needs_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q.cke) |-> $past(clk_stable));

  // R2: precharge all is a single-cycle command
  a_r2_pre_single: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q.cmd == CMD_PREALL) |=> (out_q.cmd != CMD_PREALL));

  // R7: non-READ release never trails READ release
  a_r7_order: assert property (@(posedge clk) disable iff (!rst_n)
    out_q.read_ok |-> out_q.nonread_ok);

  // R9: READ is never granted while the sequencer owns the bus
  a_r9_busy_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
    out_q.busy |-> !out_q.read_ok);

  // R10: while busy, a new entry request leaves the bus ownership unchanged
  a_r10_enter_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q.busy && out_q.nonread_ok && !rd_hit) |=> out_q.busy);

endmodule

// File: rtl/lp_selfref_seq.sv
module lp_selfref_seq
  import lp_seq_pkg::*;
#(
  parameter int CLK_PS      = 7500,
  parameter int TRP_PS      = 20000,
  parameter int TXSNR_PS    = 75000,
  parameter int TXSRD_CYC   = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter_req,
  input  logic       exit_req,
  input  logic       clk_stable,
  input  logic       banks_open,
  output logic       cke,
  output logic [2:0] cmd,
  output logic       busy,
  output logic       nonread_ok,
  output logic       read_ok
);

  localparam int RP_CYC = (ps_to_cycles(TRP_PS, CLK_PS) < 1) ? 1 : ps_to_cycles(TRP_PS, CLK_PS);
  localparam int NR_CYC = (ps_to_cycles(TXSNR_PS, CLK_PS) < 1) ? 1 : ps_to_cycles(TXSNR_PS, CLK_PS);
  localparam int WW     = $clog2(TXSRD_CYC + 2);
  localparam logic [WW-1:0] WTOP = WW'(TXSRD_CYC + 1);

  logic     srst_n;
  logic     timer_run, rp_hit, nr_hit, rd_hit;
  seq_out_t seq_out;

  lp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  lp_seq_timer #(
    .RP_CYC (RP_CYC),
    .NR_CYC (NR_CYC),
    .RD_CYC (TXSRD_CYC)
  ) u_timer (
    .clk    (clk),
    .rst_n  (srst_n),
    .run    (timer_run),
    .rp_hit (rp_hit),
    .nr_hit (nr_hit),
    .rd_hit (rd_hit)
  );

  lp_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (srst_n),
    .enter_req  (enter_req),
    .exit_req   (exit_req),
    .clk_stable (clk_stable),
    .banks_open (banks_open),
    .rp_hit     (rp_hit),
    .nr_hit     (nr_hit),
    .rd_hit     (rd_hit),
    .timer_run  (timer_run),
    .out_q      (seq_out)
  );

  assign cke        = seq_out.cke;
  assign cmd        = seq_out.cmd;
  assign busy       = seq_out.busy;
  assign nonread_ok = seq_out.nonread_ok;
  assign read_ok    = seq_out.read_ok;

  // Checker: cycles elapsed since clock enable last rose.
  logic          cke_d1;
  logic [WW-1:0] since_rise;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cke_d1     <= 1'b1;
      since_rise <= WTOP;
    end else begin
      cke_d1 <= cke;
      if (cke && !cke_d1)        since_rise <= WW'(1);
      else if (since_rise != WTOP) since_rise <= since_rise + 1'b1;
    end
  end

  // R7: non-READ release lands exactly NR cycles after clock enable rises
  a_r7_nr_delay: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(nonread_ok) |-> (since_rise == WW'(NR_CYC)));

  // R8: READ release lands exactly TXSRD_CYC cycles after clock enable rises
  a_r8_rd_delay: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(read_ok) |-> (since_rise == WW'(TXSRD_CYC)));

  // R8: bus ownership ends together with READ release
  a_r8_busy_with_read: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(busy) |-> $rose(read_ok));

endmodule

// File: tb/lp_selfref_seq_bench.sv
module lp_selfref_seq_bench;
  import lp_seq_pkg::*;

  localparam int CLK_PS    = 7500;
  localparam int TRP_PS    = 20000;
  localparam int TXSNR_PS  = 30000;
  localparam int TXSRD_CYC = 24;
  localparam int EXP_RP    = (TRP_PS + CLK_PS - 1) / CLK_PS;
  localparam int EXP_NR    = (TXSNR_PS + CLK_PS - 1) / CLK_PS;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       enter_req, exit_req, clk_stable, banks_open;
  logic       cke, busy, nonread_ok, read_ok;
  logic [2:0] cmd;
  int         cyc = 0;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lp_selfref_seq #(
    .CLK_PS    (CLK_PS),
    .TRP_PS    (TRP_PS),
    .TXSNR_PS  (TXSNR_PS),
    .TXSRD_CYC (TXSRD_CYC)
  ) u_lp_selfref_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .enter_req  (enter_req),
    .exit_req   (exit_req),
    .clk_stable (clk_stable),
    .banks_open (banks_open),
    .cke        (cke),
    .cmd        (cmd),
    .busy       (busy),
    .nonread_ok (nonread_ok),
    .read_ok    (read_ok)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int exp_aref(input int t0, input bit open);
    return open ? t0 + EXP_RP : t0;
  endfunction

  function automatic int exp_rise(input int t_ar, input int te, input int ts);
    return max3(t_ar + 2, te, ts);
  endfunction

  task automatic idle_outputs(input string req, input string what);
    chk(req, {what, " cke"}, int'(cke), 1);
    chk(req, {what, " cmd"}, int'(cmd), int'(CMD_NOP));
    chk(req, {what, " busy"}, int'(busy), 0);
    chk(req, {what, " nonread_ok"}, int'(nonread_ok), 1);
    chk(req, {what, " read_ok"}, int'(read_ok), 1);
  endtask

  // Called just after a falling edge with the block idle.
  // Exit is sampled at edge t0+ex_off; clk_stable is first sampled high at t0+st_off.
  task automatic episode(input bit open, input int ex_off, input int st_off, input bit poke);
    int t0, te, ts, t_ar, t_ck;
    int pre_at = -1;
    int ar_at = -1;
    int ck_at = -1;
    int nr_at = -1;
    int rd_at = -1;
    int bs_at = -1;
    int bf_at = -1;
    int nop_bad = 0;
    int ar_cke = 1;
    bit pcke, pnr, prd, pbusy;
    t0 = cyc + 1;
    te = t0 + ex_off;
    ts = t0 + st_off;
    banks_open = open;
    enter_req  = 1'b1;
    exit_req   = (te == t0);
    clk_stable = (ts <= t0);
    pcke = cke; pnr = nonread_ok; prd = read_ok; pbusy = busy;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (cmd == CMD_PREALL && pre_at < 0) pre_at = cyc;
      if (cmd == CMD_AREF && ar_at < 0) begin
        ar_at  = cyc;
        ar_cke = int'(cke);
      end
      if (cmd == CMD_AREF && cyc != ar_at) nop_bad++;
      if (!cke && cmd != CMD_NOP && cmd != CMD_AREF) nop_bad++;
      if (cke && !pcke && ck_at < 0) ck_at = cyc;
      if (nonread_ok && !pnr && nr_at < 0) nr_at = cyc;
      if (read_ok && !prd && rd_at < 0) rd_at = cyc;
      if (busy && !pbusy && bs_at < 0) bs_at = cyc;
      if (!busy && pbusy && bf_at < 0) bf_at = cyc;
      if (busy && read_ok) nop_bad++;
      pcke = cke; pnr = nonread_ok; prd = read_ok; pbusy = busy;
      enter_req  = poke && (cyc + 1 == te);
      exit_req   = (cyc + 1 == te);
      clk_stable = (cyc + 1 >= ts);
      banks_open = 1'($urandom_range(0, 1));
      if (bf_at >= 0) break;
    end
    enter_req  = 1'b0;
    exit_req   = 1'b0;
    clk_stable = 1'b1;
    banks_open = 1'b0;
    t_ar = exp_aref(t0, open);
    t_ck = exp_rise(t_ar, te, ts);
    chk(open ? "R2" : "R3", "precharge cycle", pre_at, open ? t0 : -1);
    chk(open ? "R2" : "R3", "auto refresh cycle", ar_at, t_ar);
    chk("R3", "cke at auto refresh", ar_cke, 0);
    chk("R4", "non-NOP commands while cke low", nop_bad, 0);
    chk((te < t_ar + 2) ? "R6" : "R5", "cke rise cycle", ck_at, t_ck);
    chk("R7", "nonread_ok rise cycle", nr_at, t_ck + EXP_NR);
    chk("R8", "read_ok rise cycle", rd_at, t_ck + TXSRD_CYC);
    chk("R9", "busy rise cycle", bs_at, t0);
    chk("R9", "busy fall cycle", bf_at, t_ck + TXSRD_CYC);
    // R10: no second entry after an ignored request
    repeat (3) @(negedge clk);
    chk("R10", "cke after episode", int'(cke), 1);
    chk("R10", "busy after episode", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n      = 1'b0;
    enter_req  = 1'b0;
    exit_req   = 1'b0;
    clk_stable = 1'b1;
    banks_open = 1'b0;
    repeat (5) @(negedge clk);
    idle_outputs("R1", "during reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    idle_outputs("R1", "after reset");

    // R10: exit request while idle is neither acted on nor remembered
    exit_req = 1'b1;
    @(negedge clk);
    exit_req = 1'b0;
    repeat (4) @(negedge clk);
    idle_outputs("R10", "idle exit pulse");
    episode(1'b1, 20, 0, 1'b0);

    // R6: exit together with the entry request, banks idle
    episode(1'b0, 0, 0, 1'b0);
    // R6: exit inside the precharge wait
    episode(1'b1, 1, 0, 1'b0);
    // R6: exit on the auto refresh cycle
    episode(1'b1, EXP_RP, 0, 1'b0);
    // R5: clock becomes stable long after the exit request; R10 entry poke
    episode(1'b1, 2, 40, 1'b1);
    episode(1'b0, 6, 30, 1'b1);

    for (int i = 0; i < 40; i++) begin
      bit open, poke;
      int ex_off, st_off;
      open   = 1'($urandom_range(0, 1));
      poke   = ($urandom_range(0, 3) == 0);
      ex_off = $urandom_range(0, 14);
      if (poke && ex_off == 0) ex_off = 1;
      st_off = ($urandom_range(0, 1) == 0) ? 0 : $urandom_range(1, 20);
      repeat ($urandom_range(0, 3)) @(negedge clk);
      episode(open, ex_off, st_off, poke);
    end

    idle_outputs("R1", "final idle");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule